// File: doc/BRIEF.md
# Single-Channel Memory Copy Engine

This block is one DMA channel. It moves a programmed number of items from a source address to a destination address through a synchronous memory master port. Software programs a source pointer, a destination pointer, an item count and a control word over a small register port. Writing the control word with its enable bit set starts the run. Each item is handled in two steps: the channel reads it, holds the data, and then writes it. An item is one, two or four bytes. Each side's pointer either advances by the item size or stays fixed, so a pointer can name a peripheral data port. A power-of-two ring window can be placed on one side to keep that pointer inside an aligned buffer.

Items can run back to back, or each one can wait for an external request level. At the end of a run the channel clears its enable and busy indications. It can raise a one-cycle interrupt, and it can pulse a trigger that carries the index of a follow-on channel. Both pointers keep their advanced values when the run ends. A follow-on run continues from where the last one stopped unless software reloads the pointers. A write to the abort register stops the channel at once.

Top module: `dma_copy_engine`

## Requirements
- R1: After reset, every register reads zero, no memory request is raised, and the interrupt and chain outputs are low.
- R2: Register offsets are 0x000 (source pointer), 0x004 (destination pointer), 0x008 (item count) and 0x00C (control). Each reads back the value last written. Control bits 21:0 read back as written, and bit 24 reads as the busy flag.
- R3: Control bits 3:2 give the item size: 0 is one byte, 1 is two bytes, 2 is four bytes. Each item reads 32-bit word addr[31:2] and takes its bytes from lane addr[1:0] upward. It is then written with data and byte enables shifted to the destination lane, and bytes outside the item are left untouched.
- R4: Control bit 4 makes the source pointer advance by the item size after each item, and bit 5 does the same for the destination pointer. When a bit is clear, that pointer stays constant.
- R5: A nonzero value S in control bits 9:6 confines one pointer to an aligned 2^S-byte window: its low S bits wrap and its upper bits stay fixed. Control bit 10 at 0 selects the source pointer and at 1 the destination pointer. S=0 disables wrapping.
- R6: The count register decrements once per completed write. When it reaches zero, the enable bit (control bit 0) and the busy flag (bit 24) clear.
- R7: At the end of a run, both pointers hold their final advanced values. Setting enable again without reloading them continues from those values.
- R8: At completion, the interrupt output is high for exactly one cycle, unless control bit 21 is set, in which case it stays low.
- R9: At completion, the chain output pulses for one cycle and the chain index output carries control bits 14:11. No pulse is made when that field equals the channel's own index.
- R10: Control bits 20:15 at 0x3F run items unpaced. Any other code starts a new item only while the request input is high.
- R11: Writing offset 0x444 with bit CHAN_ID set stops the channel at once. Busy and enable clear, no interrupt is raised, and no further memory request is issued. Writes with only other bits set have no effect.
- R12: A memory request keeps valid and its direction until it is accepted by ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 12 | Register byte offset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational from regAddr) |
| dreqIn | input | 1 | Pacing request level |
| memReqValid | output | 1 | Memory request valid |
| memReqReady | input | 1 | Memory request accepted |
| memReqWrite | output | 1 | 1 for write, 0 for read |
| memReqAddr | output | ADDR_W | Byte address of the item |
| memReqWdata | output | 32 | Write data, lane-aligned |
| memReqBe | output | 4 | Write byte enables |
| memRspValid | input | 1 | Read data valid |
| memRspRdata | input | 32 | Read data word |
| irqOut | output | 1 | Completion interrupt pulse |
| chainTrig | output | 1 | Chain trigger pulse |
| chainIdx | output | CHAN_W | Index of the channel to trigger |

## Verification
The bench sweeps every item size against every aligned lane offset and every combination of the two increment bits. It compares the whole memory against a byte-level reference, so a lane shift or byte-enable error shows up as a corrupted neighbour byte or a misplaced item. Ring windows of 4, 8 and 16 bytes are exercised on each side. A mask that is off by one would let the pointer leave the window or wrap early, and that changes both the copied data and the final pointer readback.

A held request level is checked to stall a paced channel completely, and an abort for another channel index is checked to change nothing. A real abort is checked to stop requests at once without an interrupt. The bench also continues a run without reloading the pointers; a design that reset its pointers at completion would rewrite the first buffer instead.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int REG_AW = 12;

  localparam logic [REG_AW-1:0] OFF_RD    = 12'h000;
  localparam logic [REG_AW-1:0] OFF_WR    = 12'h004;
  localparam logic [REG_AW-1:0] OFF_CNT   = 12'h008;
  localparam logic [REG_AW-1:0] OFF_CTRL  = 12'h00C;
  localparam logic [REG_AW-1:0] OFF_ABORT = 12'h444;

  localparam logic [5:0] TREQ_PERM = 6'h3F;

  typedef enum logic [1:0] {
    S_IDLE,
    S_RD_REQ,
    S_RD_WAIT,
    S_WR_REQ
  } chanState_e;

  typedef struct packed {
    logic [1:0] size;
    logic       rdInc;
    logic       wrInc;
    logic [3:0] ringSize;
    logic       ringSel;
  } xferCfg_t;

  typedef struct packed {
    logic capture;
    logic advance;
  } dpStrobe_t;
endpackage

// File: rtl/dma_datapath.sv
module dma_datapath
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  input  xferCfg_t          cfg,
  input  dpStrobe_t         strobe,
  input  logic [31:0]       memRspRdata,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [CNT_W-1:0]  count,
  output logic              cntZero,
  output logic [31:0]       wrData,
  output logic [3:0]        wrBe
);
  logic rdAddrWr, wrAddrWr, cntWr;
  logic [2:0] stepBytes;
  logic [3:0] laneMask;
  logic [31:0] itemMask, rdShifted, holdData;
  logic [ADDR_W-1:0] rdNext, wrNext;

  assign rdAddrWr = regWrEn && (regAddr == OFF_RD);
  assign wrAddrWr = regWrEn && (regAddr == OFF_WR);
  assign cntWr    = regWrEn && (regAddr == OFF_CNT);

  always_comb begin
    case (cfg.size)
      2'd0: begin stepBytes = 3'd1; laneMask = 4'b0001; itemMask = 32'h0000_00FF; end
      2'd1: begin stepBytes = 3'd2; laneMask = 4'b0011; itemMask = 32'h0000_FFFF; end
      default: begin stepBytes = 3'd4; laneMask = 4'b1111; itemMask = 32'hFFFF_FFFF; end
    endcase
  end

  function automatic logic [ADDR_W-1:0] advanceAddr(
    input logic [ADDR_W-1:0] a,
    input logic [2:0]        step,
    input logic              wrapOn,
    input logic [3:0]        rs
  );
    logic [ADDR_W-1:0] sum, mask;
    sum  = a + ADDR_W'(step);
    mask = (ADDR_W'(1) << rs) - ADDR_W'(1);
    if (wrapOn && (rs != 4'd0)) return (a & ~mask) | (sum & mask);
    return sum;
  endfunction

  assign rdNext = cfg.rdInc ? advanceAddr(rdAddr, stepBytes, !cfg.ringSel, cfg.ringSize) : rdAddr;
  assign wrNext = cfg.wrInc ? advanceAddr(wrAddr, stepBytes,  cfg.ringSel, cfg.ringSize) : wrAddr;

  assign rdShifted = memRspRdata >> {rdAddr[1:0], 3'b000};
  assign wrData    = holdData << {wrAddr[1:0], 3'b000};
  assign wrBe      = laneMask << wrAddr[1:0];
  assign cntZero   = (count == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdAddr   <= '0;
      wrAddr   <= '0;
      count    <= '0;
      holdData <= '0;
    end else begin
      if (rdAddrWr)           rdAddr <= regWrData[ADDR_W-1:0];
      else if (strobe.advance) rdAddr <= rdNext;
      if (wrAddrWr)           wrAddr <= regWrData[ADDR_W-1:0];
      else if (strobe.advance) wrAddr <= wrNext;
      if (cntWr)              count  <= regWrData[CNT_W-1:0];
      else if (strobe.advance) count  <= count - CNT_W'(1);
      if (strobe.capture)     holdData <= rdShifted & itemMask;
    end
  end

  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !cntWr) |=> (count == $past(count) - CNT_W'(1)));

  // R5
  ring_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && cfg.rdInc && !cfg.ringSel && (cfg.ringSize != 4'd0) && !rdAddrWr)
    |=> ((rdAddr >> $past(cfg.ringSize)) == ($past(rdAddr) >> $past(cfg.ringSize))));

  // R4
  fixed_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !cfg.wrInc && !wrAddrWr) |=> $stable(wrAddr));
endmodule

// File: rtl/dma_control.sv
module dma_control
  import dma_pkg::*;
#(
  parameter int CHAN_ID = 0,
  parameter int CHAN_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWr,
  input  logic [21:0]       ctrlWrData,
  input  logic              abortHit,
  input  logic              dreqIn,
  input  logic              memReqReady,
  input  logic              memRspValid,
  input  logic              cntZero,
  output xferCfg_t          cfg,
  output dpStrobe_t         strobe,
  output logic              memReqValid,
  output logic              memReqWrite,
  output logic [31:0]       ctrlRd,
  output logic              irqOut,
  output logic              chainTrig,
  output logic [CHAN_W-1:0] chainIdx
);
  chanState_e state, stateNext;
  logic enBit, hiPri, quiet, busy, paceOk, finishNow;
  logic [CHAN_W-1:0] chainTo;
  logic [5:0] treqSel;

  assign busy      = enBit;
  assign paceOk    = (treqSel == TREQ_PERM) || dreqIn;
  assign finishNow = (state == S_IDLE) && enBit && cntZero && !abortHit;
  assign chainIdx  = chainTo;

  assign memReqValid = (state == S_RD_REQ) || (state == S_WR_REQ);
  assign memReqWrite = (state == S_WR_REQ);
  assign strobe.capture = (state == S_RD_WAIT) && memRspValid && !abortHit;
  assign strobe.advance = (state == S_WR_REQ) && memReqReady;

  assign ctrlRd = {7'd0, busy, 2'd0, quiet, treqSel, chainTo, cfg.ringSel, cfg.ringSize,
                   cfg.wrInc, cfg.rdInc, cfg.size, hiPri, enBit};

  always_comb begin
    stateNext = state;
    case (state)
      S_IDLE:    if (enBit && !cntZero && paceOk) stateNext = S_RD_REQ;
      S_RD_REQ:  if (memReqReady) stateNext = S_RD_WAIT;
      S_RD_WAIT: if (memRspValid) stateNext = S_WR_REQ;
      S_WR_REQ:  if (memReqReady) stateNext = S_IDLE;
      default:   stateNext = S_IDLE;
    endcase
    if (abortHit) stateNext = S_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      enBit     <= 1'b0;
      hiPri     <= 1'b0;
      quiet     <= 1'b0;
      chainTo   <= '0;
      treqSel   <= '0;
      cfg       <= '0;
      irqOut    <= 1'b0;
      chainTrig <= 1'b0;
    end else begin
      state     <= stateNext;
      irqOut    <= finishNow && !quiet;
      chainTrig <= finishNow && (chainTo != CHAN_W'(CHAN_ID));
      if (ctrlWr) begin
        hiPri        <= ctrlWrData[1];
        cfg.size     <= ctrlWrData[3:2];
        cfg.rdInc    <= ctrlWrData[4];
        cfg.wrInc    <= ctrlWrData[5];
        cfg.ringSize <= ctrlWrData[9:6];
        cfg.ringSel  <= ctrlWrData[10];
        chainTo      <= ctrlWrData[14:11];
        treqSel      <= ctrlWrData[20:15];
        quiet        <= ctrlWrData[21];
      end
      if (abortHit)       enBit <= 1'b0;
      else if (ctrlWr)    enBit <= ctrlWrData[0];
      else if (finishNow) enBit <= 1'b0;
    end
  end

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady && !abortHit) |=> (memReqValid && $stable(memReqWrite)));

  // R8
  irq_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (!busy && $past(busy)));

  // R9
  chain_self_chk: assert property (@(posedge clk) disable iff (!rstN)
    chainTrig |-> ($past(chainTo) != CHAN_W'(CHAN_ID)));

  // R11
  abort_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    abortHit |=> (!busy && !memReqValid));

  // R10
  pace_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqWrite && ($past(state) == S_IDLE)) |-> $past(paceOk));
endmodule

// File: rtl/dma_copy_engine.sv
module dma_copy_engine
  import dma_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 32,
  parameter int CHAN_ID = 0,
  parameter int CHAN_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              dreqIn,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic              memReqWrite,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [31:0]       memReqWdata,
  output logic [3:0]        memReqBe,
  input  logic              memRspValid,
  input  logic [31:0]       memRspRdata,
  output logic              irqOut,
  output logic              chainTrig,
  output logic [CHAN_W-1:0] chainIdx
);
  xferCfg_t  cfg;
  dpStrobe_t strobe;
  logic [ADDR_W-1:0] rdAddr, wrAddr;
  logic [CNT_W-1:0]  count;
  logic [31:0] ctrlRd, wrData;
  logic [3:0]  wrBe;
  logic cntZero, ctrlWr, abortHit;

  assign ctrlWr   = regWrEn && (regAddr == OFF_CTRL);
  assign abortHit = regWrEn && (regAddr == OFF_ABORT) && regWrData[CHAN_ID];

  dma_control #(.CHAN_ID(CHAN_ID), .CHAN_W(CHAN_W)) uCtrl (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlWrData(regWrData[21:0]),
    .abortHit(abortHit), .dreqIn(dreqIn), .memReqReady(memReqReady),
    .memRspValid(memRspValid), .cntZero(cntZero), .cfg(cfg), .strobe(strobe),
    .memReqValid(memReqValid), .memReqWrite(memReqWrite), .ctrlRd(ctrlRd),
    .irqOut(irqOut), .chainTrig(chainTrig), .chainIdx(chainIdx)
  );

  dma_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .cfg(cfg), .strobe(strobe), .memRspRdata(memRspRdata),
    .rdAddr(rdAddr), .wrAddr(wrAddr), .count(count), .cntZero(cntZero),
    .wrData(wrData), .wrBe(wrBe)
  );

  assign memReqAddr  = memReqWrite ? wrAddr : rdAddr;
  assign memReqWdata = wrData;
  assign memReqBe    = memReqWrite ? wrBe : 4'b1111;

  always_comb begin
    case (regAddr)
      OFF_RD:   regRdData = 32'(rdAddr);
      OFF_WR:   regRdData = 32'(wrAddr);
      OFF_CNT:  regRdData = 32'(count);
      OFF_CTRL: regRdData = ctrlRd;
      default:  regRdData = '0;
    endcase
  end
endmodule

// File: tb/tb_dma_copy_engine.sv
module tb_dma_copy_engine;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, regWrEn, dreqIn, memReqValid, memReqReady, memReqWrite;
  logic memRspValid, irqOut, chainTrig;
  logic [11:0] regAddr;
  logic [31:0] regWrData, regRdData, memReqAddr, memReqWdata, memRspRdata;
  logic [3:0] memReqBe, chainIdx;

  dma_copy_engine dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .dreqIn(dreqIn),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqWrite(memReqWrite),
    .memReqAddr(memReqAddr), .memReqWdata(memReqWdata), .memReqBe(memReqBe),
    .memRspValid(memRspValid), .memRspRdata(memRspRdata), .irqOut(irqOut),
    .chainTrig(chainTrig), .chainIdx(chainIdx)
  );

  logic [31:0] mem [64];
  logic [7:0]  refB [256];
  logic [3:0]  rdyCnt = 4'd0;
  int vecs = 0, bad = 0, irqSeen = 0, chainSeen = 0, reqSeen = 0, holdViol = 0;
  logic [3:0] lastChain = 4'd0;
  logic prevStall = 1'b0, prevWrite = 1'b0;
  bit finished = 0;

  function automatic logic [7:0] patByte(input int b);
    return 8'(b * 37 + 11);
  endfunction

  assign memReqReady = (rdyCnt[1:0] != 2'b11);

  always @(posedge clk) begin
    rdyCnt <= rdyCnt + 4'd1;
    memRspValid <= 1'b0;
    if (!rstN) begin
      for (int i = 0; i < 64; i++)
        mem[i] <= {patByte(4*i+3), patByte(4*i+2), patByte(4*i+1), patByte(4*i)};
    end else if (memReqValid && memReqReady) begin
      reqSeen <= reqSeen + 1;
      if (memReqWrite) begin
        for (int k = 0; k < 4; k++)
          if (memReqBe[k]) mem[memReqAddr[7:2]][8*k +: 8] <= memReqWdata[8*k +: 8];
      end else begin
        memRspValid <= 1'b1;
        memRspRdata <= mem[memReqAddr[7:2]];
      end
    end
    if (irqOut) irqSeen <= irqSeen + 1;
    if (chainTrig) begin chainSeen <= chainSeen + 1; lastChain <= chainIdx; end
    if (rstN && prevStall && !(regWrEn && regAddr == 12'h444) &&
        (!memReqValid || memReqWrite != prevWrite)) holdViol <= holdViol + 1;
    prevStall <= memReqValid && !memReqReady;
    prevWrite <= memReqWrite;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [11:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  function automatic logic [31:0] mkCtrl(input bit en, input int sz, input bit ri, input bit wi,
      input int rs, input bit rsel, input int chainTo, input int treq, input bit quiet);
    return 32'(en) | (32'(sz) << 2) | (32'(ri) << 4) | (32'(wi) << 5) | (32'(rs) << 6) |
           (32'(rsel) << 10) | (32'(chainTo) << 11) | (32'(treq) << 15) | (32'(quiet) << 21);
  endfunction

  function automatic logic [31:0] nextA(input logic [31:0] a, input int step, input bit ringOn, input int rs);
    logic [31:0] mask;
    if (ringOn && rs != 0) begin
      mask = (32'd1 << rs) - 32'd1;
      return (a & ~mask) | ((a + 32'(step)) & mask);
    end
    return a + 32'(step);
  endfunction

  task automatic refCopy(input logic [31:0] src, input logic [31:0] dst, input int cnt, input int sz,
      input bit ri, input bit wi, input int rs, input bit rsel,
      output logic [31:0] endR, output logic [31:0] endW);
    int step;
    step = 1 << sz;
    endR = src; endW = dst;
    for (int n = 0; n < cnt; n++) begin
      for (int k = 0; k < step; k++) refB[8'(endW + k)] = refB[8'(endR + k)];
      if (ri) endR = nextA(endR, step, !rsel, rs);
      if (wi) endW = nextA(endW, step, rsel, rs);
    end
  endtask

  task automatic compareMem(input string tag);
    int miss;
    logic [31:0] firstAct, firstExp;
    miss = 0; firstAct = '0; firstExp = '0;
    for (int i = 0; i < 64; i++) begin
      if (mem[i] !== {refB[4*i+3], refB[4*i+2], refB[4*i+1], refB[4*i]}) begin
        if (miss == 0) begin
          firstAct = mem[i];
          firstExp = {refB[4*i+3], refB[4*i+2], refB[4*i+1], refB[4*i]};
        end
        miss++;
      end
    end
    check(miss == 0, tag, firstAct, firstExp);
  endtask

  task automatic waitIdle(input string tag);
    logic [31:0] v;
    bit idle;
    idle = 0;
    for (int i = 0; i < 4000 && !idle; i++) begin
      regRead(12'h00C, v);
      if (!v[24]) idle = 1;
      else @(negedge clk);
    end
    check(idle, tag, 32'd0, 32'd1);
  endtask

  task automatic runXfer(input logic [31:0] src, input logic [31:0] dst, input int cnt, input int sz,
      input bit ri, input bit wi, input int rs, input bit rsel, input int chainTo, input bit quiet,
      input string tag);
    int irqBase, chBase;
    logic [31:0] endR, endW, v;
    irqBase = irqSeen; chBase = chainSeen;
    regWrite(12'h000, src);
    regWrite(12'h004, dst);
    regWrite(12'h008, 32'(cnt));
    regWrite(12'h00C, mkCtrl(1, sz, ri, wi, rs, rsel, chainTo, 6'h3F, quiet));
    waitIdle({tag, " R6 completion"});
    repeat (2) @(negedge clk);
    refCopy(src, dst, cnt, sz, ri, wi, rs, rsel, endR, endW);
    compareMem({tag, " R3 R4 R5 memory"});
    regRead(12'h000, v); check(v == endR, {tag, " R7 R4 R5 source end"}, v, endR);
    regRead(12'h004, v); check(v == endW, {tag, " R7 R4 R5 dest end"}, v, endW);
    regRead(12'h008, v); check(v == 0, {tag, " R6 count"}, v, 0);
    regRead(12'h00C, v); check(v[0] == 0 && v[24] == 0, {tag, " R6 enable/busy"}, v, 0);
    check(irqSeen - irqBase == (quiet ? 0 : 1), {tag, " R8 irq pulses"},
          32'(irqSeen - irqBase), quiet ? 0 : 1);
    check(chainSeen - chBase == (chainTo != 0 ? 1 : 0), {tag, " R9 chain pulses"},
          32'(chainSeen - chBase), chainTo != 0 ? 1 : 0);
    if (chainTo != 0) check(lastChain == 4'(chainTo), {tag, " R9 chain index"}, 32'(lastChain), 32'(chainTo));
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    vecs++; bad++;
    $display("FAIL watchdog R6 actual=%h expected=%h", 32'd0, 32'd1);
    summary();
  end

  initial begin
    logic [31:0] v, endR, endW;
    int irqBase, reqBase;
    for (int b = 0; b < 256; b++) refB[b] = patByte(b);
    rstN = 1'b0; regWrEn = 1'b0; regAddr = '0; regWrData = '0; dreqIn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    regRead(12'h00C, v); check(v == 0, "R1 control", v, 0);
    regRead(12'h008, v); check(v == 0, "R1 count", v, 0);
    check(!memReqValid && !irqOut && !chainTrig, "R1 outputs idle",
          {29'd0, memReqValid, irqOut, chainTrig}, 0);

    // R2 register readback
    regWrite(12'h000, 32'h1234_5678); regRead(12'h000, v); check(v == 32'h1234_5678, "R2 source", v, 32'h1234_5678);
    regWrite(12'h004, 32'h0BAD_F00D); regRead(12'h004, v); check(v == 32'h0BAD_F00D, "R2 dest", v, 32'h0BAD_F00D);
    regWrite(12'h008, 32'h0000_0ACE); regRead(12'h008, v); check(v == 32'h0000_0ACE, "R2 count", v, 32'h0ACE);
    regWrite(12'h00C, mkCtrl(0, 2, 1, 0, 5, 1, 3, 6'h11, 1) | 32'h2);
    regRead(12'h00C, v);
    check(v == (mkCtrl(0, 2, 1, 0, 5, 1, 3, 6'h11, 1) | 32'h2), "R2 control", v,
          mkCtrl(0, 2, 1, 0, 5, 1, 3, 6'h11, 1) | 32'h2);

    // R3 R4 R8 R9 sweep of sizes, lanes and increment modes
    for (int sz = 0; sz < 3; sz++)
      for (int off = 0; off < 4; off += (1 << sz))
        for (int mode = 0; mode < 4; mode++)
          runXfer(32'h20 + 32'(off), 32'h60 + 32'((off + (1 << sz)) & (sz == 2 ? 0 : 3)), 3, sz,
                  mode[0], mode[1], 0, 0, (sz + off) % 4, mode[0] ^ off[0], "sweep");

    // R5 ring windows on each side
    for (int rsel = 0; rsel < 2; rsel++)
      for (int rs = 2; rs < 5; rs++)
        runXfer(32'h30, 32'h90, 6, 2, 1, 1, rs, rsel[0], 1, 0, "ring");

    // R7 continue without reload
    runXfer(32'h00, 32'hA0, 4, 2, 1, 1, 0, 0, 0, 1, "rerun first");
    regWrite(12'h008, 32'd4);
    regWrite(12'h00C, mkCtrl(1, 2, 1, 1, 0, 0, 0, 6'h3F, 1));
    waitIdle("R7 rerun busy");
    repeat (2) @(negedge clk);
    refCopy(32'h10, 32'hB0, 4, 2, 1, 1, 0, 0, endR, endW);
    compareMem("R7 continued copy");
    regRead(12'h000, v); check(v == 32'h20, "R7 continued source end", v, 32'h20);

    // R10 pacing by request input
    dreqIn = 1'b0;
    regWrite(12'h000, 32'h40); regWrite(12'h004, 32'hD0); regWrite(12'h008, 32'd4);
    reqBase = reqSeen;
    regWrite(12'h00C, mkCtrl(1, 1, 1, 1, 0, 0, 0, 5, 1));
    repeat (30) @(negedge clk);
    check(reqSeen == reqBase, "R10 stalled without request", 32'(reqSeen - reqBase), 0);
    regRead(12'h008, v); check(v == 4, "R10 count held", v, 4);
    dreqIn = 1'b1;
    waitIdle("R10 paced completion");
    repeat (2) @(negedge clk);
    refCopy(32'h40, 32'hD0, 4, 1, 1, 1, 0, 0, endR, endW);
    compareMem("R10 paced memory");

    // R11 abort
    regWrite(12'h000, 32'h00); regWrite(12'h004, 32'h80); regWrite(12'h008, 32'd30);
    irqBase = irqSeen;
    regWrite(12'h00C, mkCtrl(1, 2, 1, 1, 0, 0, 0, 6'h3F, 0));
    repeat (20) @(negedge clk);
    regWrite(12'h444, 32'h2);
    regRead(12'h00C, v); check(v[24] == 1, "R11 other channel abort ignored", v, 32'h0100_0000);
    repeat (20) @(negedge clk);
    regWrite(12'h444, 32'h1);
    regRead(12'h00C, v); check(v[24] == 0 && v[0] == 0, "R11 busy cleared", v, 0);
    regRead(12'h008, v); check(v > 0 && v < 30, "R11 count mid-run", v, 15);
    repeat (3) @(negedge clk);
    reqBase = reqSeen;
    repeat (20) @(negedge clk);
    check(reqSeen == reqBase, "R11 no further requests", 32'(reqSeen - reqBase), 0);
    check(irqSeen == irqBase, "R11 no interrupt", 32'(irqSeen - irqBase), 0);
    for (int i = 0; i < 64; i++)
      for (int k = 0; k < 4; k++) refB[4*i+k] = mem[i][8*k +: 8];

    // R12 request hold across back-pressure
    check(holdViol == 0, "R12 request held until ready", 32'(holdViol), 0);

    summary();
  end
endmodule